// File: doc/BRIEF.md
# Single-Function PCI Configuration Header with Write Masks

This block holds the 256-byte type-0 configuration space of one PCI function as a register file. A requester presents a byte offset, an access length of one to four bytes and, for writes, a little-endian data word. Every byte the access touches passes through its own write rule. Identity bytes are constants. The command byte accepts only its lowest bit. The low status byte cannot be changed. A whole window of header offsets refuses writes that start inside it. The two I/O base registers always keep their space-indicator bit set and their reserved bit clear. All remaining bytes store what is written.

Two I/O bases are decoded from the space and driven straight to the address decoders: a power-management base with a 64-byte window and a system-management base with a 16-byte window. A base is reported as changed by a single-cycle strobe only when a write really alters one of the four bytes of its register. Read data comes back registered, one cycle after the request.

Top module: `cfg_space_hdr`

## Requirements
- R1: Bytes 0x00..0x03 always read 0x86, 0x80, 0x13, 0x71 (vendor 0x8086, device 0x7113). Byte 0x0A reads 0x80, byte 0x0B reads 0x06, byte 0x0E reads 0x00 and byte 0x3D reads 0x01. Writes to any of these bytes have no effect.
- R2: After reset, bytes read as follows: 0x04, 0x05 and 0x3C are 0x00; 0x06 is 0x80; 0x07 is 0x02; 0x40 and 0x90 are 0x01; 0x41..0x43 and 0x91..0x93 are 0x00; 0x5F is 0x90; 0x63 is 0x60; 0x67 is 0x98. Every other non-identity byte is 0x00.
- R3: A read of length 1..4 sets rd_valid in the cycle after the request. Byte k of the access (offset+k) is returned in rd_data bits [8k+7:8k], and unused upper lanes are zero. A read of length 0 or greater than 4 returns 0xFFFFFFFF.
- R4: A write that covers byte 0x04 updates only bit 0 of that byte. Bits 7..1 keep their previous value.
- R5: Writes to byte 0x06 are discarded. Byte 0x07 stores written values normally.
- R6: A write whose starting offset lies in 0x10..0x33 changes no byte at all, including bytes at or beyond 0x34 that the access covers.
- R7: A write to byte 0x40 or 0x90 stores the value with bit 1 cleared and bit 0 set. Bytes 0x41..0x43 and 0x91..0x93 store the written value unchanged.
- R8: pm_base equals bits [15:6] of the 16-bit value {byte 0x41, byte 0x40}. sm_base equals bits [15:4] of {byte 0x91, byte 0x90}.
- R9: pm_base_chg (sm_base_chg) is high for exactly the one cycle after a write that changes any of bytes 0x40..0x43 (0x90..0x93). It stays low after a write that leaves those bytes unchanged.
- R10: A write of length 0 or greater than 4 changes nothing. Byte addresses of an access wrap modulo 256, so an access at offset 0xFE with length 4 covers 0xFE, 0xFF, 0x00 and 0x01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | 8 | Starting byte offset |
| req_len | input | 3 | Access length in bytes |
| req_wdata | input | 32 | Write data, byte k in bits [8k+7:8k] |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| pm_base | output | 10 | Power-management I/O base, address bits [15:6] |
| pm_base_chg | output | 1 | One-cycle strobe on a change of the PM base register |
| sm_base | output | 12 | System-management I/O base, address bits [15:4] |
| sm_base_chg | output | 1 | One-cycle strobe on a change of the SM base register |

## Verification
The assertions assume that req_valid lasts one cycle per access. They also assume that requests never appear while reset is asserted, because a base strobe is tied to a write in the cycle before it. The bench meets both assumptions. It drives every request for a single clock on the falling edge and releases reset before the first request. The random mix deliberately includes illegal lengths and offsets that wrap past 0xFF or start inside the locked window, because the rules under test depend on both the access length and the access offset.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;

   typedef enum logic [2:0] {
      BK_PLAIN   = 3'd0,
      BK_IDENT   = 3'd1,
      BK_CMD     = 3'd2,
      BK_DISCARD = 3'd3,
      BK_BASE_LO = 3'd4
   } byte_kind_e;

   localparam int CMD_LO_OFS  = 'h04;
   localparam int STAT_LO_OFS = 'h06;

   localparam logic [7:0] CMD_WMASK   = 8'h01;
   localparam logic [7:0] BASE_SETBIT = 8'h01;
   localparam logic [7:0] BASE_CLRBIT = 8'h02;

   function automatic bit is_ident(int a);
      return (a >= 0 && a <= 3) || a == 'h0A || a == 'h0B || a == 'h0E || a == 'h3D;
   endfunction

   function automatic byte_kind_e kind_of(int a, int pm_ofs, int sm_ofs);
      if (is_ident(a))              return BK_IDENT;
      if (a == CMD_LO_OFS)          return BK_CMD;
      if (a == STAT_LO_OFS)         return BK_DISCARD;
      if (a == pm_ofs || a == sm_ofs) return BK_BASE_LO;
      return BK_PLAIN;
   endfunction

   function automatic logic [7:0] ident_val(int a, logic [15:0] vendor, logic [15:0] device,
                                            logic [7:0] cls_sub, logic [7:0] cls_base,
                                            logic [7:0] hdr, logic [7:0] pin);
      case (a)
         0:       return vendor[7:0];
         1:       return vendor[15:8];
         2:       return device[7:0];
         3:       return device[15:8];
         'h0A:    return cls_sub;
         'h0B:    return cls_base;
         'h0E:    return hdr;
         'h3D:    return pin;
         default: return 8'h00;
      endcase
   endfunction

   function automatic logic [7:0] rst_val(int a, int pm_ofs, int sm_ofs);
      if (a == pm_ofs || a == sm_ofs) return BASE_SETBIT;
      case (a)
         'h06:    return 8'h80;
         'h07:    return 8'h02;
         'h5F:    return 8'h90;
         'h63:    return 8'h60;
         'h67:    return 8'h98;
         default: return 8'h00;
      endcase
   endfunction

endpackage

// File: rtl/cfg_byte_steer.sv
module cfg_byte_steer #(
   parameter int ADDR_W    = 8,
   parameter int LEN_W     = 3,
   parameter int LANES     = 4,
   parameter int BYTE_ADDR = 0
) (
   input  logic                   wr_ok,
   input  logic [ADDR_W-1:0]      ofs,
   input  logic [LEN_W-1:0]       len,
   input  logic [LANES*8-1:0]     wdata,
   output logic                   we,
   output logic [7:0]             wbyte
);
   localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;
   localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(BYTE_ADDR);

   logic [ADDR_W-1:0] lane;
   logic [ADDR_W-1:0] len_ext;

   // position of this byte inside the access, modulo the space size (R10)
   assign lane    = MY_ADDR - ofs;
   assign len_ext = ADDR_W'(len);
   assign we      = wr_ok && (lane < len_ext);
   assign wbyte   = wdata[lane[LANE_W-1:0]*8 +: 8];

endmodule

// File: rtl/cfg_byte_cell.sv
module cfg_byte_cell
   import cfg_hdr_pkg::*;
#(
   parameter byte_kind_e KIND    = BK_PLAIN,
   parameter logic [7:0] RST_VAL = 8'h00
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       we,
   input  logic [7:0] wbyte,
   output logic [7:0] q
);
   logic [7:0] nxt;

   generate
      if (KIND == BK_CMD) begin : g_cmd
         assign nxt = (q & ~CMD_WMASK) | (wbyte & CMD_WMASK);
      end else if (KIND == BK_BASE_LO) begin : g_base
         assign nxt = (wbyte & ~BASE_CLRBIT) | BASE_SETBIT;
      end else begin : g_plain
         assign nxt = wbyte;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= RST_VAL;
      else if (we) q <= nxt;
   end

endmodule

// File: rtl/cfg_read_port.sv
module cfg_read_port #(
   parameter int ADDR_W = 8,
   parameter int LEN_W  = 3,
   parameter int LANES  = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        rd_req,
   input  logic [ADDR_W-1:0]           ofs,
   input  logic [LEN_W-1:0]            len,
   input  logic [(1<<ADDR_W)*8-1:0]    space,
   output logic                        rd_valid,
   output logic [LANES*8-1:0]          rd_data
);
   localparam int DW = LANES * 8;

   logic          len_ok;
   logic [DW-1:0] gathered;

   assign len_ok = (len != '0) && (int'(len) <= LANES);

   always_comb begin
      gathered = '0;
      for (int i = 0; i < LANES; i++) begin
         logic [ADDR_W-1:0] idx;
         idx = ofs + ADDR_W'(i);
         if (i < int'(len)) gathered[i*8 +: 8] = space[int'(idx)*8 +: 8];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= rd_req;
         if (rd_req) rd_data <= len_ok ? gathered : {DW{1'b1}};
      end
   end

   AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> rd_valid);                                               // R3
   AST_RD_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_req |=> !rd_valid);                                             // R3
   AST_BAD_LEN_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !len_ok) |=> (rd_data == {DW{1'b1}}));                   // R3

endmodule

// File: rtl/cfg_base_track.sv
module cfg_base_track #(
   parameter int          WIN_LOG2 = 6,
   parameter logic [31:0] RST_WORD = 32'h0000_0001
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [31:0]           word,
   output logic [15-WIN_LOG2:0]  base,
   output logic                  chg
);
   logic [31:0] prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= RST_WORD;
      else        prev <= word;
   end

   assign base = word[15:WIN_LOG2];
   assign chg  = (word != prev);

endmodule

// File: rtl/cfg_space_hdr.sv
module cfg_space_hdr
   import cfg_hdr_pkg::*;
#(
   parameter int          ADDR_W      = 8,
   parameter int          LEN_W       = 3,
   parameter int          LANES       = 4,
   parameter int          PM_WIN_LOG2 = 6,
   parameter int          SM_WIN_LOG2 = 4,
   parameter int          PM_OFS      = 'h40,
   parameter int          SM_OFS      = 'h90,
   parameter int          LOCK_LO     = 'h10,
   parameter int          LOCK_HI     = 'h33,
   parameter logic [15:0] VENDOR_ID   = 16'h8086,
   parameter logic [15:0] DEVICE_ID   = 16'h7113,
   parameter logic [7:0]  CLASS_SUB   = 8'h80,
   parameter logic [7:0]  CLASS_BASE  = 8'h06,
   parameter logic [7:0]  HDR_TYPE    = 8'h00,
   parameter logic [7:0]  INT_PIN     = 8'h01
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   input  logic                  req_write,
   input  logic [ADDR_W-1:0]     req_offset,
   input  logic [LEN_W-1:0]      req_len,
   input  logic [LANES*8-1:0]    req_wdata,
   output logic                  rd_valid,
   output logic [LANES*8-1:0]    rd_data,
   output logic [15-PM_WIN_LOG2:0] pm_base,
   output logic                  pm_base_chg,
   output logic [15-SM_WIN_LOG2:0] sm_base,
   output logic                  sm_base_chg
);
   localparam int NBYTES   = 1 << ADDR_W;
   localparam int SPACE_W  = NBYTES * 8;
   localparam int LOCK_TOP = LOCK_HI + LANES;

   initial begin
      assert (ADDR_W >= 8 && ADDR_W <= 10) else $error("ADDR_W out of range");
      assert (LANES == 4) else $error("LANES must be 4 (32-bit data path)");
      assert ((1 << LEN_W) > LANES) else $error("LEN_W too narrow");
      assert (PM_WIN_LOG2 >= 2 && PM_WIN_LOG2 <= 15) else $error("PM window");
      assert (SM_WIN_LOG2 >= 2 && SM_WIN_LOG2 <= 15) else $error("SM window");
      assert (PM_OFS + 3 < NBYTES && SM_OFS + 3 < NBYTES) else $error("base offset");
      assert (LOCK_LO <= LOCK_HI && LOCK_TOP <= NBYTES) else $error("lock window");
   end

   logic [SPACE_W-1:0] space;
   logic               wr_fire;
   logic               len_ok;
   logic               start_locked;
   logic               wr_ok;

   assign wr_fire      = req_valid && req_write;
   assign len_ok       = (req_len != '0) && (int'(req_len) <= LANES);
   assign start_locked = (int'(req_offset) >= LOCK_LO) && (int'(req_offset) <= LOCK_HI);
   assign wr_ok        = wr_fire && len_ok && !start_locked;

   // one generate branch per byte; the kind of each offset picks the variant
   generate
      for (genvar a = 0; a < NBYTES; a++) begin : g_byte
         localparam byte_kind_e K = kind_of(a, PM_OFS, SM_OFS);
         if (K == BK_IDENT) begin : g_id
            assign space[a*8 +: 8] = ident_val(a, VENDOR_ID, DEVICE_ID, CLASS_SUB,
                                               CLASS_BASE, HDR_TYPE, INT_PIN);
         end else if (K == BK_DISCARD) begin : g_fixed
            assign space[a*8 +: 8] = rst_val(a, PM_OFS, SM_OFS);
         end else begin : g_reg
            logic       we;
            logic [7:0] wbyte;
            cfg_byte_steer #(
               .ADDR_W(ADDR_W), .LEN_W(LEN_W), .LANES(LANES), .BYTE_ADDR(a)
            ) u_steer (
               .wr_ok(wr_ok), .ofs(req_offset), .len(req_len), .wdata(req_wdata),
               .we(we), .wbyte(wbyte)
            );
            cfg_byte_cell #(
               .KIND(K), .RST_VAL(rst_val(a, PM_OFS, SM_OFS))
            ) u_cell (
               .clk(clk), .rst_n(rst_n), .we(we), .wbyte(wbyte), .q(space[a*8 +: 8])
            );
         end
      end
   endgenerate

   cfg_read_port #(
      .ADDR_W(ADDR_W), .LEN_W(LEN_W), .LANES(LANES)
   ) u_rd (
      .clk(clk), .rst_n(rst_n), .rd_req(req_valid && !req_write),
      .ofs(req_offset), .len(req_len), .space(space),
      .rd_valid(rd_valid), .rd_data(rd_data)
   );

   cfg_base_track #(
      .WIN_LOG2(PM_WIN_LOG2), .RST_WORD({24'h0, BASE_SETBIT})
   ) u_pm (
      .clk(clk), .rst_n(rst_n), .word(space[PM_OFS*8 +: 32]),
      .base(pm_base), .chg(pm_base_chg)
   );

   cfg_base_track #(
      .WIN_LOG2(SM_WIN_LOG2), .RST_WORD({24'h0, BASE_SETBIT})
   ) u_sm (
      .clk(clk), .rst_n(rst_n), .word(space[SM_OFS*8 +: 32]),
      .base(sm_base), .chg(sm_base_chg)
   );

   AST_PM_CHG_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      pm_base_chg |-> $past(wr_fire));                                    // R9
   AST_SM_CHG_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      sm_base_chg |-> $past(wr_fire));                                    // R9
   AST_LOCK_ZONE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_fire && start_locked) |=> $stable(space[LOCK_TOP*8-1 : LOCK_LO*8])); // R6
   AST_CMD_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(space[CMD_LO_OFS*8+7 : CMD_LO_OFS*8+1]));                    // R4
   AST_BAD_LEN_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_fire && !len_ok) |=> $stable(space));                            // R10

endmodule

// File: tb/cfg_space_hdr_tb.sv
`timescale 1ns/1ps
module cfg_space_hdr_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [7:0]  req_offset = '0;
   logic [2:0]  req_len = '0;
   logic [31:0] req_wdata = '0;
   logic        rd_valid;
   logic [31:0] rd_data;
   logic [9:0]  pm_base;
   logic        pm_base_chg;
   logic [11:0] sm_base;
   logic        sm_base_chg;

   int n_checks = 0;
   int n_fail   = 0;
   logic [7:0] m [256];

   always #4 clk = ~clk;

   cfg_space_hdr dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_offset(req_offset), .req_len(req_len), .req_wdata(req_wdata),
      .rd_valid(rd_valid), .rd_data(rd_data), .pm_base(pm_base),
      .pm_base_chg(pm_base_chg), .sm_base(sm_base), .sm_base_chg(sm_base_chg)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic bit ident_byte(int a);
      return (a <= 3) || a == 'h0A || a == 'h0B || a == 'h0E || a == 'h3D;
   endfunction

   task automatic model_reset();
      for (int a = 0; a < 256; a++) m[a] = 8'h00;
      m[0] = 8'h86; m[1] = 8'h80; m[2] = 8'h13; m[3] = 8'h71;
      m['h0A] = 8'h80; m['h0B] = 8'h06; m['h3D] = 8'h01;
      m[6] = 8'h80; m[7] = 8'h02; m['h40] = 8'h01; m['h90] = 8'h01;
      m['h5F] = 8'h90; m['h63] = 8'h60; m['h67] = 8'h98;
   endtask

   function automatic logic [31:0] exp_read(int ofs, int len);
      logic [31:0] v = 32'h0;
      if (len == 0 || len > 4) return 32'hFFFF_FFFF;
      for (int i = 0; i < len; i++) v[i*8 +: 8] = m[(ofs + i) & 255];
      return v;
   endfunction

   // apply the write rules to the model; report base-register changes
   task automatic model_write(int ofs, int len, logic [31:0] d, output bit pmc, output bit smc);
      logic [7:0] b;
      int a;
      pmc = 0; smc = 0;
      if (len == 0 || len > 4) return;
      if (ofs >= 'h10 && ofs <= 'h33) return;
      for (int i = 0; i < len; i++) begin
         a = (ofs + i) & 255;
         b = d[i*8 +: 8];
         if (ident_byte(a) || a == 6) continue;
         if (a == 4) b = {m[4][7:1], b[0]};
         if (a == 'h40 || a == 'h90) b = (b & 8'hFC) | 8'h01;
         if (m[a] != b) begin
            if (a >= 'h40 && a <= 'h43) pmc = 1;
            if (a >= 'h90 && a <= 'h93) smc = 1;
         end
         m[a] = b;
      end
   endtask

   task automatic check_bases(string tag);
      chk({tag, " R8 pm_base"}, 32'(pm_base), 32'({m['h41], m['h40]} >> 6));
      chk({tag, " R8 sm_base"}, 32'(sm_base), 32'({m['h91], m['h90]} >> 4));
   endtask

   task automatic do_read(int ofs, int len, string tag);
      @(negedge clk);
      req_valid = 1; req_write = 0; req_offset = 8'(ofs); req_len = 3'(len);
      @(negedge clk);
      req_valid = 0;
      chk({tag, " R3 rd_valid"}, 32'(rd_valid), 32'd1);
      chk(tag, rd_data, exp_read(ofs, len));
   endtask

   task automatic do_write(int ofs, int len, logic [31:0] d, string tag);
      bit pmc, smc;
      @(negedge clk);
      req_valid = 1; req_write = 1; req_offset = 8'(ofs); req_len = 3'(len); req_wdata = d;
      model_write(ofs, len, d, pmc, smc);
      @(negedge clk);
      req_valid = 0;
      chk({tag, " R9 pm_chg"}, 32'(pm_base_chg), 32'(pmc));
      chk({tag, " R9 sm_chg"}, 32'(sm_base_chg), 32'(smc));
      check_bases(tag);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin : main
      int unsigned seed;
      seed = 32'd1234;
      void'($urandom(seed));
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk("R3 rd_valid idle after reset", 32'(rd_valid), 0);
      chk("R9 no chg after reset", 32'({pm_base_chg, sm_base_chg}), 0);
      check_bases("R2 reset");
      for (int a = 0; a < 256; a += 4) do_read(a, 4, "R2 reset dump");
      chk("R1 identity literal", exp_read(0, 4), 32'h7113_8086);
      do_read(0, 4, "R1 identity");

      do_write(0, 4, 32'hFFFF_FFFF, "R1 write identity");
      do_read(0, 4, "R1 identity after write");
      do_write('h3C, 2, 32'h0000_5A5A, "R1 pin write");
      do_read('h3C, 2, "R1 pin kept");
      do_read(0, 0, "R3 len0");
      do_read(0, 5, "R3 len5");
      do_read(0, 7, "R3 len7");
      do_read('h0A, 2, "R3 two lanes");
      do_write(4, 2, 32'h0000_FFFF, "R4 cmd all ones");
      do_read(4, 2, "R4 cmd bit0 only");
      chk("R4 cmd literal", exp_read(4, 2), 32'h0000_FF01);
      do_write(4, 1, 32'h0000_00FE, "R4 cmd clear");
      do_read(4, 1, "R4 cmd cleared");
      do_write(6, 2, 32'h0000_1234, "R5 status");
      do_read(6, 2, "R5 status low locked");
      chk("R5 status literal", exp_read(6, 2), 32'h0000_1280);
      do_write('h32, 4, 32'hDEAD_BEEF, "R6 locked span");
      do_read('h32, 4, "R6 locked span read");
      do_write('h10, 1, 32'h0000_0077, "R6 locked start");
      do_read('h10, 1, "R6 locked start read");
      do_write('h0F, 2, 32'h0000_3344, "R6 start below window");
      do_read('h0F, 2, "R6 spill into window");
      do_write('h40, 4, 32'h0000_F0FF, "R7 pm base");
      chk("R7 pm literal", 32'(pm_base), 32'h3C3);
      @(negedge clk);
      chk("R9 pm pulse one cycle", 32'(pm_base_chg), 0);
      do_write('h40, 4, 32'h0000_F0FF, "R9 pm same value");
      do_write('h43, 1, 32'h0000_0055, "R9 pm high byte");
      do_write('h90, 2, 32'h0000_1234, "R7 sm base");
      chk("R7 sm literal", 32'(sm_base), 32'h123);
      do_read('h90, 4, "R7 sm readback");
      do_write('h50, 5, 32'hFFFF_FFFF, "R10 bad len");
      do_write('h50, 0, 32'hFFFF_FFFF, "R10 zero len");
      do_read('h50, 4, "R10 bad len read");
      do_write('hFE, 4, 32'hAABB_CCDD, "R10 wrap");
      do_read('hFE, 4, "R10 wrap read");

      for (int n = 0; n < 3000; n++) begin
         int ofs, len;
         ofs = int'($urandom() & 255);
         case ($urandom() % 8)
            0:       ofs = 'h3C + int'($urandom() % 8);
            1:       ofs = 'h8E + int'($urandom() % 8);
            default: ;
         endcase
         len = int'($urandom() % 6);
         if ($urandom() % 2 == 0) do_write(ofs, len, $urandom(), "R7 random write");
         else                     do_read(ofs, len, "R3 random read");
      end
      for (int a = 0; a < 256; a += 4) do_read(a, 4, "R10 final dump");

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule